// File: doc/BRIEF.md
# Floating-Point Instruction Microsequencer

This block is the control sequencer of a floating-point coprocessor. A `start` pulse in idle captures a decoded instruction: its class, two operand-zero flags and a compare flag. The sequencer then walks a four-state common prolog. The first prolog state strobes the floating status/control word into scratch register 7, word 0, through the accumulator input multiplexer. After the prolog the sequencer forks on instruction class into a named path.

A load of the status word and a store of the status word each take a short fixed path. Any other memory-operand instruction takes a single placeholder state. Register-only arithmetic (add, subtract, compare) passes a second fork state and enters a decision tree. That tree exits early for a zero source or a zero destination, sets up the fraction and exponent operands, and finally forks on a live exponent-range code into an alignment state or a compare exit.

The datapath, bus cycles and the range ROM are outside the block. The block drives the state code and a set of control strobes, at most one of which is high at a time. A trace pair (`trace_vld`, `trace_code`) reports every visited state, so a bench can compare whole sequences.

Top module: `fp_microseq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the sequencer in idle (state code 0) in the next cycle, with `done`, `ctl_stb` and `trace_vld` all 0.
- R2: When `start` is high at an edge while idle, the state codes in the following four cycles are 1, 2, 3 and 4. `instr_cls` is encoded as follows: 0 selects load-status, 1 selects store-status, 2 selects register-only arithmetic and 3 selects any other memory operation.
- R3: Strobe bit 0 (status word into scratch register) is high exactly in state 1. No more than one `ctl_stb` bit is ever high.
- R4: The load-status path follows the prolog with codes 5 and then 6. Strobe bit 1 (load status) is high in state 6.
- R5: The store-status path follows the prolog with codes 7, 8 and 9. Strobe bit 2 (store status) is high in state 9.
- R6: Any other memory-operand class follows the prolog with code 10 only, and this state drives no strobe.
- R7: The register-only path follows the prolog with codes 11, 12, 13, 14, 15, 16, 17 and 18. Strobe bit 3 (exponent subtract) is high in state 17.
- R8: If the source is zero, state 12 goes to code 22. If the destination is zero (and the source is nonzero), state 13 goes to code 23. A zero source takes priority over a zero destination. Strobe bit 5 (copy result) is high in states 22 and 23.
- R9: State 18 samples `rng_code` live. Range 0 (exponents equal) and range 3 go to code 19. Range 1 (destination smaller) goes to code 20. Range 2 (destination larger) goes to code 21. Strobe bit 4 (fraction ALU) is high in states 19, 20 and 21.
- R10: When the compare flag was captured, state 18 goes to code 24 whatever the range code is. Zero-operand exits still take priority.
- R11: `done` is high for exactly one cycle: the final state of a path. The next cycle is idle. `trace_vld` is high in every non-idle cycle, and `trace_code` equals the state code.
- R12: `start` is ignored while busy. Class and flags are captured at start, and input changes during an instruction have no effect on its path.
- R13: No state code appears twice within one instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled in idle) |
| instr_cls | input | 2 | Decoded instruction class |
| src_zero | input | 1 | Source operand is zero |
| dst_zero | input | 1 | Destination operand is zero |
| is_cmp | input | 1 | Instruction is a compare |
| rng_code | input | 2 | Exponent-range code from the range ROM |
| state_code | output | 5 | Current state code |
| ctl_stb | output | 6 | Control strobes, at most one high |
| done | output | 1 | Final state of the current instruction |
| trace_vld | output | 1 | A state is being reported |
| trace_code | output | 5 | Reported state code |

## Verification
The first prolog state is due in the cycle after the edge that samples `start`. After that, each following state arrives exactly one cycle later, because the only register on the path is the state register, and strobes and `done` decode from that register in the same cycle. The bench drives inputs and samples outputs at the falling edge. It records one trace entry per falling edge from the first prolog state until `done`, then expects idle at the next falling edge. A reset applied mid-instruction is expected to show idle one falling edge later.

// File: rtl/fpseq_pkg.sv
package fpseq_pkg;

  localparam int STATE_W = 5;
  localparam int CLS_W   = 2;
  localparam int RNG_W   = 2;
  localparam int STB_W   = 6;

  localparam int STB_FPS_SCR  = 0;
  localparam int STB_FPS_LOAD = 1;
  localparam int STB_FPS_STOR = 2;
  localparam int STB_EXP_SUB  = 3;
  localparam int STB_FRAC_ALU = 4;
  localparam int STB_RES_COPY = 5;

  typedef enum logic [STATE_W-1:0] {
    S_IDLE      = 5'd0,
    S_PRO0      = 5'd1,
    S_PRO1      = 5'd2,
    S_PRO2      = 5'd3,
    S_PRO3      = 5'd4,
    S_LDS_A     = 5'd5,
    S_LDS_B     = 5'd6,
    S_STS_A     = 5'd7,
    S_STS_B     = 5'd8,
    S_STS_C     = 5'd9,
    S_MEM_A     = 5'd10,
    S_REG_FORK  = 5'd11,
    S_AR_ENTRY  = 5'd12,
    S_AR_DZCHK  = 5'd13,
    S_AR_CMPCHK = 5'd14,
    S_AR_FRAC   = 5'd15,
    S_AR_EXPA   = 5'd16,
    S_AR_EXPB   = 5'd17,
    S_AR_RANGE  = 5'd18,
    S_AL_EQ     = 5'd19,
    S_AL_SHD    = 5'd20,
    S_AL_SHS    = 5'd21,
    S_ZS_EXIT   = 5'd22,
    S_ZD_EXIT   = 5'd23,
    S_CMP_EXIT  = 5'd24
  } seq_state_e;

  typedef enum logic [CLS_W-1:0] {
    CLS_LDSTAT = 2'd0,
    CLS_STSTAT = 2'd1,
    CLS_REGOP  = 2'd2,
    CLS_MEMOP  = 2'd3
  } instr_cls_e;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic             src_zero;
    logic             dst_zero;
    logic             cmp;
  } instr_ctx_t;

  // final state of every path: done is raised there
  function automatic logic is_final(seq_state_e s);
    case (s)
      S_LDS_B, S_STS_C, S_MEM_A, S_AL_EQ, S_AL_SHD, S_AL_SHS,
      S_ZS_EXIT, S_ZD_EXIT, S_CMP_EXIT: return 1'b1;
      default:                          return 1'b0;
    endcase
  endfunction

  // exponent-range fork target; spare code aligns as equal
  function automatic seq_state_e align_target(logic [RNG_W-1:0] r);
    case (r)
      2'd1:    return S_AL_SHD;
      2'd2:    return S_AL_SHS;
      default: return S_AL_EQ;
    endcase
  endfunction

  // which strobe a state raises, -1 for none
  function automatic int strobe_slot(seq_state_e s);
    case (s)
      S_PRO0:                       return STB_FPS_SCR;
      S_LDS_B:                      return STB_FPS_LOAD;
      S_STS_C:                      return STB_FPS_STOR;
      S_AR_EXPB:                    return STB_EXP_SUB;
      S_AL_EQ, S_AL_SHD, S_AL_SHS:  return STB_FRAC_ALU;
      S_ZS_EXIT, S_ZD_EXIT:         return STB_RES_COPY;
      default:                      return -1;
    endcase
  endfunction

endpackage

// File: rtl/fpseq_ctx_reg.sv
module fpseq_ctx_reg
  import fpseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  instr_ctx_t ctx_in,
  output instr_ctx_t ctx_q
);

  always_ff @(posedge clk) begin
    if (rst)       ctx_q <= '0;
    else if (load) ctx_q <= ctx_in;
  end

endmodule

// File: rtl/fpseq_next.sv
module fpseq_next
  import fpseq_pkg::*;
(
  input  seq_state_e       cur,
  input  logic             start,
  input  instr_ctx_t       ctx,
  input  logic [RNG_W-1:0] rng,
  output seq_state_e       nxt
);

  always_comb begin
    nxt = S_IDLE;
    case (cur)
      S_IDLE:      nxt = start ? S_PRO0 : S_IDLE;
      S_PRO0:      nxt = S_PRO1;
      S_PRO1:      nxt = S_PRO2;
      S_PRO2:      nxt = S_PRO3;
      S_PRO3: begin
        case (ctx.cls)
          CLS_LDSTAT: nxt = S_LDS_A;
          CLS_STSTAT: nxt = S_STS_A;
          CLS_REGOP:  nxt = S_REG_FORK;
          default:    nxt = S_MEM_A;
        endcase
      end
      S_LDS_A:     nxt = S_LDS_B;
      S_STS_A:     nxt = S_STS_B;
      S_STS_B:     nxt = S_STS_C;
      S_REG_FORK:  nxt = S_AR_ENTRY;
      S_AR_ENTRY:  nxt = ctx.src_zero ? S_ZS_EXIT : S_AR_DZCHK;
      S_AR_DZCHK:  nxt = ctx.dst_zero ? S_ZD_EXIT : S_AR_CMPCHK;
      S_AR_CMPCHK: nxt = S_AR_FRAC;
      S_AR_FRAC:   nxt = S_AR_EXPA;
      S_AR_EXPA:   nxt = S_AR_EXPB;
      S_AR_EXPB:   nxt = S_AR_RANGE;
      S_AR_RANGE:  nxt = ctx.cmp ? S_CMP_EXIT : align_target(rng);
      default:     nxt = S_IDLE;  // final states and unused codes
    endcase
  end

endmodule

// File: rtl/fpseq_outdec.sv
module fpseq_outdec
  import fpseq_pkg::*;
(
  input  seq_state_e       st,
  output logic [STB_W-1:0] stb,
  output logic             done
);

  for (genvar i = 0; i < STB_W; i++) begin : g_stb
    assign stb[i] = (strobe_slot(st) == i);
  end

  assign done = is_final(st);

endmodule

// File: rtl/fp_microseq.sv
module fp_microseq
  import fpseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CLS_W-1:0]   instr_cls,
  input  logic               src_zero,
  input  logic               dst_zero,
  input  logic               is_cmp,
  input  logic [RNG_W-1:0]   rng_code,
  output logic [STATE_W-1:0] state_code,
  output logic [STB_W-1:0]   ctl_stb,
  output logic               done,
  output logic               trace_vld,
  output logic [STATE_W-1:0] trace_code
);

  seq_state_e cur_st;
  seq_state_e nxt_st;
  instr_ctx_t ctx_in;
  instr_ctx_t ctx_q;
  logic       ctx_load;
  logic       cap_cmp_w;

  assign ctx_in   = '{cls: instr_cls, src_zero: src_zero, dst_zero: dst_zero, cmp: is_cmp};
  assign ctx_load = start && (cur_st == S_IDLE);
  assign cap_cmp_w = ctx_q.cmp;

  fpseq_ctx_reg u_ctx (
    .clk    (clk),
    .rst    (rst),
    .load   (ctx_load),
    .ctx_in (ctx_in),
    .ctx_q  (ctx_q)
  );

  fpseq_next u_next (
    .cur   (cur_st),
    .start (start),
    .ctx   (ctx_q),
    .rng   (rng_code),
    .nxt   (nxt_st)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_st <= S_IDLE;
    else     cur_st <= nxt_st;
  end

  fpseq_outdec u_dec (
    .st   (cur_st),
    .stb  (ctl_stb),
    .done (done)
  );

  assign state_code = cur_st;
  assign trace_vld  = (cur_st != S_IDLE);
  assign trace_code = cur_st;

endmodule

// File: rtl/fp_microseq_chk.sv
module fp_microseq_chk
  import fpseq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [STATE_W-1:0] state_code,
  input logic [STB_W-1:0]   ctl_stb,
  input logic               done,
  input logic               busy,
  input logic               cap_cmp,
  input logic [RNG_W-1:0]   rng_code
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (state_code == S_IDLE) && !done && (ctl_stb == '0)); // R1

  AST_START_PROLOG: assert property (@(posedge clk) disable iff (rst)
    (state_code == S_IDLE && start) |=> state_code == S_PRO0); // R2

  AST_PROLOG_STEP: assert property (@(posedge clk) disable iff (rst)
    (state_code == S_PRO0 || state_code == S_PRO1 || state_code == S_PRO2)
    |=> state_code == $past(state_code) + STATE_W'(1)); // R2

  AST_SCR_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> ctl_stb[STB_FPS_SCR]); // R3

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl_stb)); // R3

  AST_RANGE_LT: assert property (@(posedge clk) disable iff (rst)
    (state_code == S_AR_RANGE && !cap_cmp && rng_code == 2'd1)
    |=> state_code == S_AL_SHD); // R9

  AST_CMP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_code == S_AR_RANGE && cap_cmp) |=> state_code == S_CMP_EXIT); // R10

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |=> state_code == S_IDLE); // R11

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R11

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R12

endmodule

bind fp_microseq fp_microseq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .state_code (state_code),
  .ctl_stb    (ctl_stb),
  .done       (done),
  .busy       (trace_vld),
  .cap_cmp    (cap_cmp_w),
  .rng_code   (rng_code)
);

// File: tb/fp_microseq_test.sv
module fp_microseq_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] instr_cls = 2'd0;
  logic       src_zero = 1'b0;
  logic       dst_zero = 1'b0;
  logic       is_cmp = 1'b0;
  logic [1:0] rng_code = 2'd0;
  logic [4:0] state_code;
  logic [5:0] ctl_stb;
  logic       done;
  logic       trace_vld;
  logic [4:0] trace_code;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_microseq uut (
    .clk(clk), .rst(rst), .start(start), .instr_cls(instr_cls),
    .src_zero(src_zero), .dst_zero(dst_zero), .is_cmp(is_cmp),
    .rng_code(rng_code), .state_code(state_code), .ctl_stb(ctl_stb),
    .done(done), .trace_vld(trace_vld), .trace_code(trace_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe pattern the requirements give for each state code
  function automatic int exp_stb(input int code);
    case (code)
      1:          return 6'b000001;
      6:          return 6'b000010;
      9:          return 6'b000100;
      17:         return 6'b001000;
      19, 20, 21: return 6'b010000;
      22, 23:     return 6'b100000;
      default:    return 0;
    endcase
  endfunction

  // issue one instruction and compare its trace with the expected list
  task automatic run_seq(input logic [1:0] cls, input logic sz, input logic dz,
                         input logic cmp, input logic [1:0] rng, input int expq[$],
                         input string req, input bit poke);
    int got[$];
    int done_idx = -1;
    int n_done = 0;
    int stb_bad = 0;
    int mism = -1;
    int dup = 0;
    @(negedge clk);
    instr_cls = cls; src_zero = sz; dst_zero = dz; is_cmp = cmp; rng_code = rng;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 32; k++) begin
      if (!trace_vld) break;
      got.push_back(int'(trace_code));
      if (int'(ctl_stb) != exp_stb(int'(trace_code))) stb_bad++;
      if (done) begin n_done++; done_idx = k; end
      if (poke && k == 2) begin
        start = 1'b1; src_zero = ~sz; dst_zero = ~dz; is_cmp = ~cmp;
        instr_cls = ~cls;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    for (int i = 0; i < expq.size(); i++)
      if (mism < 0 && (i >= got.size() || got[i] != expq[i])) mism = i;
    if (mism < 0 && got.size() != expq.size()) mism = expq.size();
    check(mism < 0, {req, " sequence (first mismatch index shown)"},
          (mism < 0) ? 0 : ((mism < got.size()) ? got[mism] : -1),
          (mism < 0) ? 0 : ((mism < expq.size()) ? expq[mism] : -1));
    check(stb_bad == 0, {req, " R3/R4/R5/R7/R8/R9 strobes per state"}, stb_bad, 0);
    check(n_done == 1 && done_idx == got.size() - 1, {req, " R11 done on last state"},
          done_idx, got.size() - 1);
    check(state_code == 5'd0 && !trace_vld, {req, " R11 idle after done"},
          int'(state_code), 0);
    foreach (got[i]) for (int j = i + 1; j < got.size(); j++) if (got[i] == got[j]) dup++;
    check(dup == 0, {req, " R13 no repeated state"}, dup, 0);
  endtask

  task automatic test_reset;
    check(state_code == 5'd0, "R1 reset state", int'(state_code), 0);
    check(ctl_stb == 6'd0 && !done && !trace_vld, "R1 reset outputs",
          int'({ctl_stb, done, trace_vld}), 0);
  endtask

  task automatic test_reset_mid;
    @(negedge clk);
    instr_cls = 2'd2; src_zero = 0; dst_zero = 0; is_cmp = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(state_code == 5'd0 && !trace_vld && ctl_stb == 6'd0 && !done,
          "R1 reset mid-instruction", int'(state_code), 0);
    rst = 1'b0;
    @(negedge clk);
    check(state_code == 5'd0, "R1 stays idle without start", int'(state_code), 0);
  endtask

  int pro[$]   = '{1, 2, 3, 4};
  int arith[$] = '{1, 2, 3, 4, 11, 12, 13, 14, 15, 16, 17, 18};

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    test_reset();
    run_seq(2'd0, 0, 0, 0, 2'd0, {pro, 5, 6}, "R2 R4 load status", 0);
    run_seq(2'd1, 0, 0, 0, 2'd0, {pro, 7, 8, 9}, "R2 R5 store status", 0);
    run_seq(2'd3, 0, 0, 0, 2'd0, {pro, 10}, "R6 other memory op", 0);
    run_seq(2'd2, 0, 0, 0, 2'd0, {arith, 19}, "R7 R9 add equal exponents", 0);
    run_seq(2'd2, 0, 0, 0, 2'd1, {arith, 20}, "R9 destination smaller", 0);
    run_seq(2'd2, 0, 0, 0, 2'd2, {arith, 21}, "R9 destination larger", 0);
    run_seq(2'd2, 0, 0, 0, 2'd3, {arith, 19}, "R9 spare range code", 0);
    run_seq(2'd2, 1, 0, 0, 2'd1, {pro, 11, 12, 22}, "R8 zero source", 0);
    run_seq(2'd2, 0, 1, 0, 2'd1, {pro, 11, 12, 13, 23}, "R8 zero destination", 0);
    run_seq(2'd2, 1, 1, 1, 2'd1, {pro, 11, 12, 22}, "R8 R10 both zero priority", 0);
    run_seq(2'd2, 0, 0, 1, 2'd2, {arith, 24}, "R10 compare exit", 0);
    run_seq(2'd2, 0, 0, 0, 2'd1, {arith, 20}, "R12 inputs ignored while busy", 1);
    test_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule